// File: doc/BRIEF.md
# UART Transmit Byte Queue with Watermark Events

This block holds the bytes that software has queued for a UART transmitter. Each strobe of the write-data register pushes one byte into a first-in first-out store of parameterised depth, 32 entries by default. The serializer takes bytes from the head through a valid/ready handshake. The head is offered only while the transmitter enable is set.

The block drives the full and empty status bits and a five-bit level field. It also gives four single-cycle event pulses. The wm_set and wm_clr pulses raise and lower the transmit watermark interrupt state. The drained pulse raises the transmit-empty interrupt state. The overflow pulse marks a write that was dropped. The interrupt state registers lie outside this block and consume the pulses. A one-cycle reset command flushes the queue.

Top module: `uart_txq`

## Requirements
- R1: A write strobe stores the low byte of the write data. The bytes come out at the head in the order they were written. The head byte is on out_data whenever out_valid is high.
- R2: A write made while the level equals the depth is discarded, and the stored bytes and the level stay as they were. The overflow pulse is high in the cycle after that write.
- R3: full is high exactly when the level equals the depth. The level never exceeds the depth.
- R4: empty is high exactly when the level is zero. After reset, empty is 1 and full is 0.
- R5: When a pop leaves the level at zero, drained_evt pulses in the following cycle. It does not pulse at any other time.
- R6: When a push that is not paired with a pop leaves the level greater than or equal to thresh, wm_set_evt pulses in the following cycle.
- R7: wm_clr_evt pulses in the following cycle in two cases. The first is a pop that is not paired with a push and leaves the level below thresh or at zero. The second is any reset command.
- R8: A one-cycle flush_req sets the level to zero at the next edge. It takes priority over a write in the same cycle, and that write is dropped without an overflow pulse. The command holds no state after that cycle.
- R9: out_valid is high only while tx_en is high and the level is nonzero. A pop happens when out_valid and out_ready are both high.
- R10: lvl_field reports the low five bits of the level, so a full 32-entry queue reads 0 there.
- R11: A push and a pop in the same cycle leave the level unchanged and produce no watermark or drain pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe of the write-data register |
| wr_data | input | 8 | Byte to queue |
| flush_req | input | 1 | One-cycle queue reset command |
| thresh | input | 6 | Watermark threshold from the FIFO control register |
| tx_en | input | 1 | Transmitter enable; gates draining |
| out_valid | output | 1 | Head byte offered to the serializer |
| out_data | output | 8 | Head byte |
| out_ready | input | 1 | Serializer accepts the head byte |
| full | output | 1 | Level equals depth |
| empty | output | 1 | Level is zero |
| lvl_field | output | 5 | Low five bits of the level |
| wm_set_evt | output | 1 | Pulse that raises the watermark interrupt state |
| wm_clr_evt | output | 1 | Pulse that lowers the watermark interrupt state |
| drained_evt | output | 1 | Pulse that raises the transmit-empty interrupt state |
| ovf_evt | output | 1 | Pulse that marks a dropped write |

## Verification
The bench fills the queue to the top and then keeps writing, with the transmitter disabled. A design that wraps its pointers there would overwrite the oldest byte, or would report a level field other than 0 with full clear. It issues flushes together with writes, so a design that lets the write win would leave one byte behind. It pairs pushes with pops at all levels, because a design that counts both would report a drift or a spurious watermark pulse. It also sweeps thresholds from 0 to the depth, where an off-by-one in the comparison shows up as a missing or extra wm_set or wm_clr pulse.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    typedef struct packed {
        logic wm_set;
        logic wm_clr;
        logic drained;
        logic ovf;
    } txq_evt_t;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned FIELD_W = 5;

endpackage

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/uart_txq_ctrl.sv
module uart_txq_ctrl
    import uart_txq_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          flush_req,
    input  logic [LW-1:0] thresh,
    input  logic          tx_en,
    input  logic          out_ready,
    output logic          push,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [LW-1:0] level,
    output logic          out_valid,
    output txq_evt_t      evt
);

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [LW-1:0] level;
        txq_evt_t      evt;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        pop;
    logic        is_full;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + AW'(1);
    endfunction

    assign is_full   = (st_q.level == FULL_LVL);
    assign out_valid = tx_en && (st_q.level != '0);
    assign pop       = out_valid && out_ready && !flush_req;
    assign push      = wr_en && !is_full && !flush_req;

    always_comb begin
        st_d     = st_q;
        st_d.evt = '0;
        if (flush_req) begin
            st_d.wptr       = '0;
            st_d.rptr       = '0;
            st_d.level      = '0;
            st_d.evt.wm_clr = 1'b1;
        end else begin
            st_d.evt.ovf = wr_en && is_full;
            if (push) begin
                st_d.wptr = next_ptr(st_q.wptr);
            end
            if (pop) begin
                st_d.rptr = next_ptr(st_q.rptr);
            end
            if (push && !pop) begin
                st_d.level      = st_q.level + LW'(1);
                st_d.evt.wm_set = (st_d.level >= thresh);
            end else if (pop && !push) begin
                st_d.level       = st_q.level - LW'(1);
                st_d.evt.wm_clr  = (st_d.level < thresh) || (st_d.level == '0);
                st_d.evt.drained = (st_d.level == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr  = st_q.wptr;
    assign rptr  = st_q.rptr;
    assign level = st_q.level;
    assign evt   = st_q.evt;

endmodule

// File: rtl/uart_txq.sv
module uart_txq
    import uart_txq_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               flush_req,
    input  logic [LW-1:0]      thresh,
    input  logic               tx_en,
    output logic               out_valid,
    output logic [BYTE_W-1:0]  out_data,
    input  logic               out_ready,
    output logic               full,
    output logic               empty,
    output logic [FIELD_W-1:0] lvl_field,
    output logic               wm_set_evt,
    output logic               wm_clr_evt,
    output logic               drained_evt,
    output logic               ovf_evt
);

    logic          push;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [LW-1:0] cur_level;
    txq_evt_t      evt;

    uart_txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .flush_req (flush_req),
        .thresh    (thresh),
        .tx_en     (tx_en),
        .out_ready (out_ready),
        .push      (push),
        .wptr      (wptr),
        .rptr      (rptr),
        .level     (cur_level),
        .out_valid (out_valid),
        .evt       (evt)
    );

    uart_txq_store #(.DEPTH(DEPTH), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (out_data)
    );

    assign full        = (cur_level == LW'(DEPTH));
    assign empty       = (cur_level == '0);
    assign lvl_field   = cur_level[FIELD_W-1:0];
    assign wm_set_evt  = evt.wm_set;
    assign wm_clr_evt  = evt.wm_clr;
    assign drained_evt = evt.drained;
    assign ovf_evt     = evt.ovf;

endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          flush_req,
    input logic          tx_en,
    input logic          out_valid,
    input logic          out_ready,
    input logic          full,
    input logic          empty,
    input logic          ovf_evt,
    input logic          drained_evt,
    input logic [LW-1:0] cur_level
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cur_level <= LW'(DEPTH)); // R3

    AST_DRAIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !out_valid); // R9

    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (cur_level == '0)); // R8

    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !flush_req) |=> ovf_evt); // R2

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush_req && !(out_valid && out_ready)) |=> full); // R2

    AST_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_level == LW'(1)) && out_valid && out_ready && !wr_en && !flush_req)
        |=> (drained_evt && empty)); // R5

    AST_PAIRED_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && wr_en && !full && !flush_req)
        |=> $stable(cur_level)); // R11

endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .flush_req   (flush_req),
    .tx_en       (tx_en),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .full        (full),
    .empty       (empty),
    .ovf_evt     (ovf_evt),
    .drained_evt (drained_evt),
    .cur_level   (cur_level)
);

// File: tb/uart_txq_tb.sv
module uart_txq_tb;

    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flush_req = 1'b0;
    logic [5:0] thresh = '0;
    logic       tx_en = 1'b0;
    logic       out_ready = 1'b0;
    logic       out_valid, full, empty;
    logic [7:0] out_data;
    logic [4:0] lvl_field;
    logic       wm_set_evt, wm_clr_evt, drained_evt, ovf_evt;

    always #10 clk = ~clk;

    uart_txq #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flush_req(flush_req), .thresh(thresh), .tx_en(tx_en),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .full(full), .empty(empty), .lvl_field(lvl_field),
        .wm_set_evt(wm_set_evt), .wm_clr_evt(wm_clr_evt),
        .drained_evt(drained_evt), .ovf_evt(ovf_evt)
    );

    int         n_checks = 0;
    int         n_fail   = 0;
    logic [7:0] mq[$];
    logic       e_set = 0, e_clr = 0, e_drn = 0, e_ovf = 0;
    logic       last_en = 0;
    bit         done = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_level();
        return mq.size();
    endfunction

    task automatic check_outputs();
        int lv = exp_level();
        chk("R3 full", int'(full), int'(lv == DEPTH));
        chk("R4 empty", int'(empty), int'(lv == 0));
        chk("R10 lvl_field", int'(lvl_field), lv % 32);
        chk("R9 out_valid", int'(out_valid), int'(last_en && lv != 0));
        if (out_valid && lv != 0) chk("R1 head byte", int'(out_data), int'(mq[0]));
        chk("R6 wm_set", int'(wm_set_evt), int'(e_set));
        chk("R7 wm_clr", int'(wm_clr_evt), int'(e_clr));
        chk("R5 drained", int'(drained_evt), int'(e_drn));
        chk("R2 overflow", int'(ovf_evt), int'(e_ovf));
    endtask

    // One cycle: check current outputs, drive inputs, predict, advance.
    task automatic step(input bit w, input logic [7:0] b, input bit fl,
                        input int th, input bit en, input bit rdy);
        int  lv;
        bit  pp, pu;
        check_outputs();
        wr_en = w; wr_data = b; flush_req = fl; thresh = 6'(th);
        tx_en = en; out_ready = rdy;
        lv = exp_level();
        e_set = 0; e_clr = 0; e_drn = 0; e_ovf = 0;
        if (fl) begin
            mq.delete();
            e_clr = 1;
        end else begin
            pp = en && rdy && lv != 0;
            pu = w && lv < DEPTH;
            e_ovf = w && lv == DEPTH;
            if (pu) mq.push_back(b);
            if (pp) void'(mq.pop_front());
            if (pu && !pp) e_set = (mq.size() >= th);
            if (pp && !pu) begin
                e_clr = (mq.size() < th) || (mq.size() == 0);
                e_drn = (mq.size() == 0);
            end
        end
        last_en = en;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        check_outputs();

        // R1 R3 R10 R2: fill to the top with draining off, then overflow
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i + 8'h40), 0, 16, 0, 1);
        chk("R3 full after fill", int'(full), 1);
        chk("R10 field wraps at full", int'(lvl_field), 0);
        step(1, 8'hEE, 0, 16, 0, 1);
        step(1, 8'hEF, 0, 16, 0, 0);
        // R1 drain all in order, R5 drained pulse at end
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 16, 1, 1);

        // R8 flush with simultaneous write
        for (int i = 0; i < 5; i++) step(1, 8'(i), 0, 3, 0, 0);
        step(1, 8'hAA, 1, 3, 0, 0);
        step(0, 0, 0, 3, 1, 1);
        chk("R8 empty after flush", int'(empty), 1);

        // R11 paired push and pop at a middle level
        for (int i = 0; i < 4; i++) step(1, 8'(i + 1), 0, 2, 0, 0);
        for (int i = 0; i < 6; i++) step(1, 8'(i + 9), 0, 2, 1, 1);
        step(0, 0, 1, 2, 0, 0);

        // Threshold edges 0 and DEPTH
        step(1, 8'h11, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1);
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 0, DEPTH, 0, 0);
        step(0, 0, 0, DEPTH, 1, 1);
        step(0, 0, 1, DEPTH, 0, 0);

        // Constrained random phases: fill-biased, drain-biased, balanced
        for (int ph = 0; ph < 30; ph++) begin
            int wp = (ph % 3 == 0) ? 90 : (ph % 3 == 1) ? 25 : 55;
            int rp = (ph % 3 == 0) ? 20 : (ph % 3 == 1) ? 90 : 55;
            int th = int'($urandom_range(0, DEPTH));
            for (int c = 0; c < 200; c++) begin
                bit w  = ($urandom_range(0, 99) < wp);
                bit r  = ($urandom_range(0, 99) < rp);
                bit en = ($urandom_range(0, 99) < 85);
                bit fl = ($urandom_range(0, 999) < 8);
                step(w, 8'($urandom()), fl, th, en, r);
            end
        end
        check_outputs();
        finish_run();
    end

endmodule